// File: doc/BRIEF.md
# ECP Tagged-FIFO Transfer Engine

This block moves bytes through an extended-capability parallel port during the data phase, after negotiation has finished. Software fills one shared FIFO through two write strobes: one queues the byte as a command (run-length count or channel address), the other queues it as plain data. Each FIFO entry holds the byte and a one-bit command tag. In the forward direction a small handshake machine takes entries off the FIFO one at a time. It puts the byte on the port, drives the host acknowledge line from the tag, and runs the strobe/busy exchange with no software involvement. In the reverse direction every falling edge of the peripheral clock line captures a byte and its tag into the FIFO, and software reads the entries back.

Compression is left to software. To send a run of repeated bytes, software queues the repeat count as a command and then queues the byte itself as data. The engine sends both without change. A service request tells the driver when to refill the FIFO (forward) or drain it (reverse), based on a programmable threshold. An enable input flushes the FIFO and stops all activity. A direction input selects forward or reverse operation.

Top module: `ecp_xfer_engine`

## Requirements
- R1: After reset the FIFO is empty (level 0, `fifo_empty`=1, `fifo_full`=0), `overflow`=0, `n_strobe`=1 (deasserted) and `host_ack`=1.
- R2: A byte written with `wr_cmd` is tagged as a command (tag 1) and leaves the port with `host_ack`=0. A byte written with `wr_dat` is tagged as data (tag 0) and leaves with `host_ack`=1.
- R3: Forward bytes leave the port in write order with their values unchanged, including a repeat-count command followed by its data byte.
- R4: The forward handshake places the byte and tag, then drives `n_strobe` low one cycle later. It holds `n_strobe` low with `pd_out`/`host_ack` stable until `busy` is seen high, then releases `n_strobe` on the next cycle. It starts no new entry until `busy` has returned low.
- R5: While a forward command byte is on the port, `fwd_rle`=1 if bit 7 is 0 (a run-length count of 0..127) and `fwd_chan`=1 if bit 7 is 1 (a channel address in bits 6:0). Both are 0 for data bytes and when no handshake is running.
- R6: In reverse mode, each falling edge of `n_periph_clk` queues `pd_in`. The entry is data (`rd_is_cmd`=0) if `periph_ack` was 1, and a command (`rd_is_cmd`=1) with bit 7 forced to 0 if `periph_ack` was 0. `rd_byte`/`rd_is_cmd` show the oldest entry, and `rd_pop` removes it.
- R7: The FIFO holds DEPTH (16) entries. A write while it is full is dropped, even if a pop happens in the same cycle, and sets `overflow`. `overflow` stays set until reset.
- R8: `svc_req` is 1 when enabled and either the direction is forward with level ≤ `thresh`, or the direction is reverse with level ≥ `thresh`. Otherwise it is 0.
- R9: With `en`=0 the FIFO is flushed to empty, writes and captures are dropped, `n_strobe` stays high and `svc_req` is 0.
- R10: Software writes have no effect in reverse mode, and peripheral clock edges have no effect in forward mode.
- R11: If `wr_cmd` and `wr_dat` are both asserted in one cycle, one command entry is queued and the data write is dropped.
- R12: In reverse mode, a capture and a `rd_pop` in the same cycle on a non-empty, non-full FIFO leave the level unchanged and advance the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | FIFO and engine enable; low flushes |
| dir | input | 1 | 0 forward, 1 reverse |
| thresh | input | 5 | Service-request threshold |
| wr_cmd | input | 1 | Queue `wr_byte` as a command |
| wr_dat | input | 1 | Queue `wr_byte` as data |
| wr_byte | input | 8 | Software write byte |
| rd_pop | input | 1 | Remove head entry (reverse) |
| rd_byte | output | 8 | Head entry byte |
| rd_is_cmd | output | 1 | Head entry tag (1 command) |
| level | output | 5 | FIFO fill level |
| fifo_empty | output | 1 | FIFO empty |
| fifo_full | output | 1 | FIFO full |
| overflow | output | 1 | Sticky dropped-write flag |
| svc_req | output | 1 | Service request |
| pd_out | output | 8 | Forward port data |
| host_ack | output | 1 | Forward tag line (0 command) |
| n_strobe | output | 1 | Forward strobe, active low |
| busy | input | 1 | Peripheral busy |
| pd_in | input | 8 | Reverse port data |
| periph_ack | input | 1 | Reverse tag line (0 command) |
| n_periph_clk | input | 1 | Reverse byte clock, captured on fall |
| fwd_rle | output | 1 | Forward command is a run-length count |
| fwd_chan | output | 1 | Forward command is a channel address |

## Verification
The FIFO has two sides that can act in the same cycle: the push side and the pop side. The bench drives a reverse-direction capture and a software `rd_pop` into the same clock edge. It does this once on a partly filled FIFO, where the level must not change and the head must advance. It does it again on a full FIFO, where the capture must be dropped and the overflow flag set while the pop still goes through. A queue model in the bench decides every outcome. The model and the threshold function are applied every cycle during a long random run that mixes captures and pops.

// File: rtl/ecp_pkg.sv
package ecp_pkg;

  typedef struct packed {
    logic       is_cmd;
    logic [7:0] b;
  } ecp_ent_t;

  typedef enum logic [1:0] {
    HS_IDLE,
    HS_SETUP,
    HS_STRB,
    HS_RELS
  } hs_st_t;

  // service wanted: forward refill when low, reverse drain when high
  function automatic logic svc_want(input logic rev, input int unsigned lvl,
                                    input int unsigned thr);
    return rev ? (lvl >= thr) : (lvl <= thr);
  endfunction

  // turn a reverse byte and its acknowledge level into a tagged entry
  function automatic ecp_ent_t rev_entry(input logic pack, input logic [7:0] d);
    ecp_ent_t e;
    e.is_cmd = !pack;
    e.b      = pack ? d : {1'b0, d[6:0]};
    return e;
  endfunction

endpackage

// File: rtl/ecp_tag_fifo.sv
module ecp_tag_fifo
  import ecp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  ecp_ent_t      push_ent,
  input  logic          pop,
  output ecp_ent_t      head,
  output logic [LW-1:0] level,
  output logic          empty,
  output logic          full,
  output logic          overflow
);

  ecp_ent_t      mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          push_ok, pop_ok, push_drop;

  assign empty     = (level == '0);
  assign full      = (level == LW'(DEPTH));
  assign push_ok   = push && !full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign push_drop = push && full && !flush;
  assign head      = mem[rp];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= push_ent;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (push_ok) wp <= bump(wp);
      if (pop_ok)  rp <= bump(rp);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         overflow <= 1'b0;
    else if (push_drop) overflow <= 1'b1;
  end

  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));
  p_drop_sets_ovf_r7: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> overflow && $stable(level) || $past(pop_ok));
  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);
  p_flush_empties_r9: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/ecp_fwd_hs.sv
module ecp_fwd_hs
  import ecp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       avail,
  input  ecp_ent_t   head,
  input  logic       busy,
  output logic       pop,
  output logic [7:0] pd_out,
  output logic       host_ack,
  output logic       n_strobe,
  output logic       fwd_rle,
  output logic       fwd_chan
);

  hs_st_t st;
  logic   active;

  assign pop      = run && avail && (st == HS_IDLE);
  assign n_strobe = (st != HS_STRB);
  assign active   = (st != HS_IDLE);
  assign fwd_rle  = active && !host_ack && !pd_out[7];
  assign fwd_chan = active && !host_ack &&  pd_out[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= HS_IDLE;
      pd_out   <= '0;
      host_ack <= 1'b1;
    end else if (!run) begin
      st <= HS_IDLE;
    end else begin
      case (st)
        HS_IDLE: if (avail) begin
          pd_out   <= head.b;
          host_ack <= !head.is_cmd;
          st       <= HS_SETUP;
        end
        HS_SETUP: st <= HS_STRB;
        HS_STRB:  if (busy)  st <= HS_RELS;
        HS_RELS:  if (!busy) st <= HS_IDLE;
        default:  st <= HS_IDLE;
      endcase
    end
  end

  p_strobe_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !n_strobe |-> $stable(pd_out) && $stable(host_ack));
  p_strobe_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!n_strobe && busy) |=> n_strobe);
  p_no_pop_while_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !busy || !$past(active));
  p_kind_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_rle && fwd_chan));

endmodule

// File: rtl/ecp_rev_cap.sv
module ecp_rev_cap
  import ecp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       n_periph_clk,
  input  logic       periph_ack,
  input  logic [7:0] pd_in,
  output logic       push,
  output ecp_ent_t   ent
);

  logic prev;

  always_ff @(posedge clk) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= n_periph_clk;
  end

  assign push = arm && prev && !n_periph_clk;
  assign ent  = rev_entry(periph_ack, pd_in);

  p_one_per_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> !push);

endmodule

// File: rtl/ecp_xfer_engine.sv
module ecp_xfer_engine
  import ecp_pkg::*;
#(
  parameter int DEPTH = 16,
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          dir,
  input  logic [LW-1:0] thresh,
  input  logic          wr_cmd,
  input  logic          wr_dat,
  input  logic [7:0]    wr_byte,
  input  logic          rd_pop,
  output logic [7:0]    rd_byte,
  output logic          rd_is_cmd,
  output logic [LW-1:0] level,
  output logic          fifo_empty,
  output logic          fifo_full,
  output logic          overflow,
  output logic          svc_req,
  output logic [7:0]    pd_out,
  output logic          host_ack,
  output logic          n_strobe,
  input  logic          busy,
  input  logic [7:0]    pd_in,
  input  logic          periph_ack,
  input  logic          n_periph_clk,
  output logic          fwd_rle,
  output logic          fwd_chan
);

  logic     fwd_on, rev_on;
  logic     sw_push, cap_push, hs_pop, sw_pop;
  ecp_ent_t sw_ent, cap_ent, head;

  assign fwd_on = en && !dir;
  assign rev_on = en &&  dir;

  // command strobe wins when both are raised together
  assign sw_push = fwd_on && (wr_cmd || wr_dat);
  assign sw_ent  = '{is_cmd: wr_cmd, b: wr_byte};
  assign sw_pop  = rev_on && rd_pop;

  ecp_rev_cap u_cap (
    .clk(clk), .rst_n(rst_n), .arm(rev_on), .n_periph_clk(n_periph_clk),
    .periph_ack(periph_ack), .pd_in(pd_in), .push(cap_push), .ent(cap_ent)
  );

  ecp_tag_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .flush(!en),
    .push(sw_push || cap_push), .push_ent(dir ? cap_ent : sw_ent),
    .pop(hs_pop || sw_pop), .head(head), .level(level),
    .empty(fifo_empty), .full(fifo_full), .overflow(overflow)
  );

  ecp_fwd_hs u_hs (
    .clk(clk), .rst_n(rst_n), .run(fwd_on), .avail(!fifo_empty), .head(head),
    .busy(busy), .pop(hs_pop), .pd_out(pd_out), .host_ack(host_ack),
    .n_strobe(n_strobe), .fwd_rle(fwd_rle), .fwd_chan(fwd_chan)
  );

  assign rd_byte   = head.b;
  assign rd_is_cmd = head.is_cmd;
  assign svc_req   = en && svc_want(dir, int'(level), int'(thresh));

  p_single_push_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(sw_push && cap_push));
  p_hs_pop_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hs_pop |-> !fifo_empty && !dir);
  p_idle_when_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> n_strobe);

endmodule

// File: tb/tb_ecp_xfer_engine.sv
`timescale 1ns/1ps
module tb_ecp_xfer_engine;

  localparam int DEPTH = 16;
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0, en = 0, dir = 0;
  logic [LW-1:0] thresh = '0;
  logic wr_cmd = 0, wr_dat = 0, rd_pop = 0, busy = 0, periph_ack = 1, n_periph_clk = 1;
  logic [7:0] wr_byte = '0, pd_in = '0;
  logic [7:0] rd_byte, pd_out;
  logic rd_is_cmd, fifo_empty, fifo_full, overflow, svc_req, host_ack, n_strobe, fwd_rle, fwd_chan;
  logic [LW-1:0] level;

  int n_chk = 0, n_bad = 0;
  logic [8:0] q[$];
  logic last_rclk = 1;
  logic exp_ovf = 0;

  always #2 clk = ~clk;

  ecp_xfer_engine #(.DEPTH(DEPTH)) dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_svc(input logic e, input logic rv, input int lv, input int th);
    if (!e) return 0;
    if (rv) return !(lv < th);
    return !(lv > th);
  endfunction

  // one reverse-mode cycle: drive at negedge, model, check at next negedge
  task automatic rev_step(input logic cap, input logic pop, input logic [7:0] d, input logic pa);
    logic acc_cap, acc_pop;
    acc_cap = cap && last_rclk;
    acc_pop = pop && (q.size() > 0);
    n_periph_clk = cap ? 1'b0 : 1'b1;
    last_rclk = n_periph_clk;
    pd_in = d; periph_ack = pa; rd_pop = pop;
    if (acc_cap && q.size() == DEPTH) exp_ovf = 1;
    if (acc_pop) void'(q.pop_front());
    if (acc_cap && (q.size() + (acc_pop ? 1 : 0)) < DEPTH + (acc_pop ? 1 : 0) &&
        !((q.size() + (acc_pop ? 1 : 0)) == DEPTH))
      q.push_back(pa ? {1'b0, d} : {1'b1, 1'b0, d[6:0]});
    @(negedge clk);
    rd_pop = 0;
    chk("R6 level", level, q.size());
    chk("R7 full", fifo_full, q.size() == DEPTH);
    chk("R7 overflow", overflow, exp_ovf);
    chk("R8 svc", svc_req, exp_svc(en, dir, q.size(), thresh));
    if (q.size() > 0) chk("R6 head", {rd_is_cmd, rd_byte}, q[0]);
  endtask

  task automatic sw_write(input logic c, input logic d, input logic [7:0] b);
    wr_cmd = c; wr_dat = d; wr_byte = b;
    @(negedge clk);
    wr_cmd = 0; wr_dat = 0;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [8:0] exp_f[$];
    logic wc[24], wd[24];
    logic [7:0] wb[24];
    int nf;
    void'($urandom(32'h1284));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 empty", fifo_empty, 1);
    chk("R1 full", fifo_full, 0);
    chk("R1 overflow", overflow, 0);
    chk("R1 n_strobe", n_strobe, 1);
    chk("R1 host_ack", host_ack, 1);

    // R9 disabled: writes dropped
    sw_write(1, 0, 8'h11);
    chk("R9 level", level, 0);
    chk("R9 svc", svc_req, 0);
    chk("R9 n_strobe", n_strobe, 1);

    // forward transfers: R2 R3 R4 R5 R11
    en = 1; dir = 0;
    nf = 20;
    wc[0] = 1; wd[0] = 0; wb[0] = 8'h05;   // run-length count
    wc[1] = 0; wd[1] = 1; wb[1] = 8'hAA;   // repeated byte
    wc[2] = 1; wd[2] = 0; wb[2] = 8'h83;   // channel address
    wc[3] = 1; wd[3] = 1; wb[3] = 8'h7F;   // both strobes: R11
    for (int i = 4; i < nf; i++) begin
      wc[i] = $urandom_range(0, 1); wd[i] = !wc[i]; wb[i] = 8'($urandom);
    end
    for (int i = 0; i < nf; i++) exp_f.push_back({wc[i], wb[i]});
    fork
      begin
        for (int i = 0; i < nf; i++) begin
          sw_write(wc[i], wd[i], wb[i]);
          repeat ($urandom_range(0, 6)) @(negedge clk);
        end
      end
      begin
        for (int j = 0; j < nf; j++) begin
          int dly;
          while (n_strobe) @(negedge clk);
          chk("R3 byte", pd_out, exp_f[j][7:0]);
          chk("R2 host_ack", host_ack, !exp_f[j][8]);
          chk("R5 rle", fwd_rle, exp_f[j][8] && !exp_f[j][7]);
          chk("R5 chan", fwd_chan, exp_f[j][8] && exp_f[j][7]);
          dly = $urandom_range(0, 3);
          repeat (dly) begin
            @(negedge clk);
            chk("R4 strobe held", n_strobe, 0);
          end
          busy = 1;
          @(negedge clk);
          chk("R4 strobe released", n_strobe, 1);
          repeat ($urandom_range(0, 3)) begin
            @(negedge clk);
            chk("R4 no strobe while busy", n_strobe, 1);
          end
          busy = 0;
        end
      end
    join
    repeat (4) @(negedge clk);
    chk("R3 drained", fifo_empty, 1);
    chk("R5 idle kinds", {fwd_rle, fwd_chan}, 0);

    // R10: peripheral clock ignored in forward
    n_periph_clk = 0; @(negedge clk); n_periph_clk = 1;
    repeat (3) @(negedge clk);
    chk("R10 fwd capture ignored", level, 0);
    chk("R10 no strobe", n_strobe, 1);

    // R7 R8 forward fill with stalled peripheral
    thresh = 4;
    sw_write(0, 1, 8'h01);
    repeat (3) @(negedge clk);
    chk("R4 stalled strobe", n_strobe, 0);
    for (int i = 0; i < 3; i++) sw_write(0, 1, 8'(i));
    chk("R8 fwd svc low", svc_req, 1);
    for (int i = 3; i < DEPTH; i++) sw_write(1, 0, 8'(i));
    chk("R7 level full", level, DEPTH);
    chk("R7 full flag", fifo_full, 1);
    chk("R7 no ovf yet", overflow, 0);
    chk("R8 fwd svc high", svc_req, 0);
    sw_write(0, 1, 8'hEE);
    chk("R7 dropped", level, DEPTH);
    chk("R7 overflow", overflow, 1);
    en = 0; @(negedge clk);
    chk("R9 flushed", fifo_empty, 1);
    chk("R9 strobe idle", n_strobe, 1);
    chk("R7 sticky", overflow, 1);
    exp_ovf = 1;

    // reverse: R10 software write ignored
    en = 1; dir = 1; thresh = 6;
    sw_write(1, 0, 8'h22);
    chk("R10 rev write ignored", level, 0);
    q.delete();
    last_rclk = 1;

    // R6 tags and MSB clearing
    rev_step(1, 0, 8'hC5, 0);
    rev_step(0, 0, 0, 1);
    rev_step(1, 0, 8'hC5, 1);
    rev_step(0, 0, 0, 1);
    // R12 capture and pop together, partial FIFO
    rev_step(1, 1, 8'h3C, 0);
    chk("R12 level same", level, 2);
    rev_step(0, 0, 0, 1);
    // fill up then R7 with simultaneous pop
    while (q.size() < DEPTH) begin
      rev_step(1, 0, 8'($urandom), 1'($urandom));
      rev_step(0, 0, 0, 1);
    end
    rev_step(1, 1, 8'h99, 1);
    chk("R7 full drop with pop", level, DEPTH - 1);
    rev_step(0, 0, 0, 1);

    // random reverse traffic
    for (int k = 0; k < 3000; k++) begin
      if (k % 500 == 0) thresh = LW'($urandom_range(0, DEPTH));
      rev_step($urandom_range(0, 9) < 6, $urandom_range(0, 9) < 4,
               8'($urandom), 1'($urandom));
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule